// File: doc/BRIEF.md
# Slot Thermal Alarm Engine

This block watches the temperature of a drive enclosure. On every strobe it takes one signed fixed-point reading from each channel. The channels are an inlet sensor, an outlet sensor and one sensor per drive slot, all delivered side by side in one sample vector. Each reading is smoothed by a first-order low-pass filter. Each channel is then checked for plausibility, and a channel that fails is marked unhealthy. From the smoothed values the block works out three kinds of metric:

- an absolute level per channel;
- a rise per sample per channel;
- relative differences: slot against inlet, outlet against inlet, and slot against its neighbours.

Each metric is compared with a programmable threshold. A condition must persist over a programmable number of consecutive samples before it raises an alarm.

There are two classes of alert. The global alert covers airflow or inlet trouble. The per-slot alerts mark a single bay whose local anomaly persists. Every threshold and count is a configuration input that a management controller holds steady. Reading the sensors, converting units and calibrating offsets happen outside this block.

Top module: `thm_alarm_engine`

## Requirements
- R1: After reset, every alarm output, the global alert and every healthy flag are low, until the first sample strobe arrives.
- R2: The first strobe after reset loads each smoothed value with the raw reading. Every later strobe sets the smoothed value to old + ((raw − old) >>> k), an arithmetic shift, where k is `cfg_shift_i` clamped to a maximum of 4. The smoothed values appear on `smooth_o` one clock after the strobe. Channel c occupies bits [c*W +: W].
- R3: A channel's healthy flag drops for a sample in any of three cases, and rises again on the next sample that is clean:
  - the raw reading lies below `cfg_min_i` or above `cfg_max_i`;
  - the raw reading differs from the previous raw reading by more than `cfg_jump_lim_i`;
  - the smoothed value has stayed unchanged for `cfg_stuck_lim_i` consecutive samples, with 0 disabling this test.
- R4: The absolute alarm of a channel is raised when its smoothed value is strictly greater than `cfg_t_high_i` for `cfg_persist_i` consecutive samples. Bit order is inlet at bit 0, outlet at bit 1, and slot i at bit i+2.
- R5: The rate alarm of a channel is raised when the rise of its smoothed value since the previous sample is strictly greater than `cfg_r_high_i` for `cfg_persist_i` consecutive samples.
- R6: Every persistence counter returns to zero on the first sample that misses its condition, and that drops the alarm. A persistence count of 0 or 1 raises the alarm on the first qualifying sample.
- R7: The system alarm is raised when outlet minus inlet is strictly greater than `cfg_dt_sys_i` for the persistence count. The comparison is made only while both the inlet and the outlet are healthy.
- R8: A healthy slot's condition holds when the slot minus the inlet is strictly greater than `cfg_dt_slot_i`. This comparison needs a healthy inlet.
- R9: A healthy slot's condition also holds when the slot minus its neighbour average is strictly greater than `cfg_dt_nbr_i`. The average is formed as follows:
  - unhealthy neighbours are skipped;
  - with two healthy neighbours, the average is their sum shifted right by one;
  - with one healthy neighbour, including the single neighbour of an end slot, that neighbour's value is used alone;
  - with no healthy neighbour, this comparison is suppressed.
- R10: `slot_alert_o[i]` is the persistent slot condition of R8 and R9. `global_alert_o` is high when the system alarm or the inlet's absolute alarm is high.
- R11: All alarm and alert outputs change exactly two clocks after the strobe. They are not yet updated one clock after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_vld_i | input | 1 | One-cycle strobe marking a new sample vector |
| samp_i | input | NCH*W | Raw readings; inlet, outlet, then slots |
| cfg_shift_i | input | 3 | Filter shift k (clamped to 4) |
| cfg_t_high_i | input | W | Absolute limit (signed) |
| cfg_r_high_i | input | W | Rise-per-sample limit (signed) |
| cfg_dt_slot_i | input | W | Slot-over-inlet limit (signed) |
| cfg_dt_sys_i | input | W | Outlet-over-inlet limit (signed) |
| cfg_dt_nbr_i | input | W | Slot-over-neighbours limit (signed) |
| cfg_min_i | input | W | Lowest plausible reading (signed) |
| cfg_max_i | input | W | Highest plausible reading (signed) |
| cfg_jump_lim_i | input | W | Largest plausible change between samples (unsigned) |
| cfg_stuck_lim_i | input | CW | Unchanged-sample count declaring a sensor stuck; 0 disables |
| cfg_persist_i | input | CW | Consecutive samples needed before an alarm |
| smooth_o | output | NCH*W | Smoothed value per channel |
| healthy_o | output | NCH | Per-channel plausibility flag |
| abs_alarm_o | output | NCH | Per-channel absolute alarm |
| rate_alarm_o | output | NCH | Per-channel rate alarm |
| slot_alert_o | output | NSLOT | Per-slot relative alert |
| sys_alarm_o | output | 1 | Outlet-over-inlet alarm |
| global_alert_o | output | 1 | Airflow or inlet alert |

## Verification
The smoothed values and the healthy flags come from the first register stage. They are due one clock after the strobe. The alarms and alerts are formed from those registered values in a second stage, and are due one clock later still.

The bench drives every strobe on a falling edge and lets two rising edges pass before it reads any result. For the timing requirement, one case also samples between the two edges, to confirm that the alarm has not moved yet. Persistence cases repeat samples one strobe at a time, so the count of qualifying samples needed is observed exactly.

// File: rtl/thm_pkg.sv
package thm_pkg;
  localparam int IDX_INLET  = 0;
  localparam int IDX_OUTLET = 1;
  localparam int SLOT_BASE  = 2;
  localparam int MAX_SHIFT  = 4;
endpackage

// File: rtl/thm_persist.sv
module thm_persist #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          cond_i,
  input  logic [CW-1:0] limit_i,
  output logic          alarm_o
);
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          alarm_q, alarm_nx;

  always_comb begin
    if (!cond_i)
      cnt_nx = '0;
    else if (cnt_q == {CW{1'b1}})
      cnt_nx = cnt_q;
    else
      cnt_nx = cnt_q + 1'b1;
    alarm_nx = cond_i && (cnt_nx >= limit_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      alarm_q <= 1'b0;
    end else if (en_i) begin
      cnt_q   <= cnt_nx;
      alarm_q <= alarm_nx;
    end
  end

  assign alarm_o = alarm_q;

  // R6: a sample that misses the condition drops the alarm
  a_r6_miss_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !cond_i) |=> !alarm_o);
  // R11: the alarm moves only on an evaluation cycle
  a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(alarm_o));
endmodule

// File: rtl/thm_chan.sv
module thm_chan
  import thm_pkg::*;
#(
  parameter int W  = 12,
  parameter int CW = 8,
  parameter int KW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vld_i,
  input  logic signed [W-1:0]  raw_i,
  input  logic [KW-1:0]        shift_i,
  input  logic signed [W-1:0]  min_i,
  input  logic signed [W-1:0]  max_i,
  input  logic [W-1:0]         jump_lim_i,
  input  logic [CW-1:0]        stuck_lim_i,
  output logic signed [W-1:0]  sm_o,
  output logic signed [W-1:0]  sm_prev_o,
  output logic                 healthy_o
);
  localparam int DW = W + 1;

  logic                seeded_q;
  logic signed [W-1:0] sm_q, prev_q, raw_prev_q;
  logic [CW-1:0]       stuck_q, stuck_nx;
  logic                healthy_q, healthy_nx;

  logic [KW-1:0]        k_eff;
  logic signed [DW-1:0] delta, step, sum, rdiff, rabs;
  logic signed [W-1:0]  sm_nx;
  logic                 jump_bad, range_bad, stuck_bad, same;

  always_comb begin
    k_eff     = (shift_i > KW'(MAX_SHIFT)) ? KW'(MAX_SHIFT) : shift_i;
    delta     = DW'(raw_i) - DW'(sm_q);
    step      = delta >>> k_eff;
    sum       = DW'(sm_q) + step;
    sm_nx     = seeded_q ? sum[W-1:0] : raw_i;
    rdiff     = DW'(raw_i) - DW'(raw_prev_q);
    rabs      = rdiff[DW-1] ? -rdiff : rdiff;
    jump_bad  = seeded_q && (rabs > $signed({1'b0, jump_lim_i}));
    range_bad = (raw_i < min_i) || (raw_i > max_i);
    same      = seeded_q && (sm_nx == sm_q);
    if (!same)
      stuck_nx = '0;
    else if (stuck_q == {CW{1'b1}})
      stuck_nx = stuck_q;
    else
      stuck_nx = stuck_q + 1'b1;
    stuck_bad  = (stuck_lim_i != '0) && (stuck_nx >= stuck_lim_i);
    healthy_nx = !(range_bad || jump_bad || stuck_bad);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seeded_q   <= 1'b0;
      sm_q       <= '0;
      prev_q     <= '0;
      raw_prev_q <= '0;
      stuck_q    <= '0;
      healthy_q  <= 1'b0;
    end else if (vld_i) begin
      seeded_q   <= 1'b1;
      sm_q       <= sm_nx;
      prev_q     <= seeded_q ? sm_q : raw_i;
      raw_prev_q <= raw_i;
      stuck_q    <= stuck_nx;
      healthy_q  <= healthy_nx;
    end
  end

  assign sm_o      = sm_q;
  assign sm_prev_o = prev_q;
  assign healthy_o = healthy_q;

  // R2: first sample after reset loads the raw value
  a_r2_seed_load: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && !seeded_q) |=> (sm_q == $past(raw_i)));
  // R2: a rising step stays between the old value and the sample
  a_r2_rise_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && seeded_q && (raw_i >= sm_q)) |=> (sm_q >= $past(sm_q) && sm_q <= $past(raw_i)));
  // R2: a falling step stays between the sample and the old value
  a_r2_fall_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && seeded_q && (raw_i < sm_q)) |=> (sm_q <= $past(sm_q) && sm_q >= $past(raw_i)));
  // R3: an out-of-range reading marks the channel unhealthy
  a_r3_range_unhealthy: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && ((raw_i < min_i) || (raw_i > max_i))) |=> !healthy_o);
endmodule

// File: rtl/thm_slot_rel.sv
module thm_slot_rel #(
  parameter int W     = 12,
  parameter int NSLOT = 4
) (
  input  logic [NSLOT*W-1:0] slot_sm_i,
  input  logic [NSLOT-1:0]   slot_ok_i,
  input  logic signed [W-1:0] inlet_sm_i,
  input  logic               inlet_ok_i,
  input  logic signed [W-1:0] dt_slot_i,
  input  logic signed [W-1:0] dt_nbr_i,
  output logic [NSLOT-1:0]   cond_o
);
  localparam int DW = W + 2;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic signed [W-1:0]  self_v, lv, rv;
    logic                 lok, rok, nbr_ok;
    logic signed [DW-1:0] nsum, navg, d_in, d_nb;

    assign self_v = $signed(slot_sm_i[i*W +: W]);

    if (i > 0) begin : g_left
      assign lv  = $signed(slot_sm_i[(i-1)*W +: W]);
      assign lok = slot_ok_i[i-1];
    end else begin : g_noleft
      assign lv  = '0;
      assign lok = 1'b0;
    end

    if (i < NSLOT-1) begin : g_right
      assign rv  = $signed(slot_sm_i[(i+1)*W +: W]);
      assign rok = slot_ok_i[i+1];
    end else begin : g_noright
      assign rv  = '0;
      assign rok = 1'b0;
    end

    always_comb begin
      nsum   = (lok ? DW'(lv) : '0) + (rok ? DW'(rv) : '0);
      navg   = (lok && rok) ? (nsum >>> 1) : nsum;
      nbr_ok = lok || rok;
      d_in   = DW'(self_v) - DW'(inlet_sm_i);
      d_nb   = DW'(self_v) - navg;
      cond_o[i] = slot_ok_i[i] &&
                  ((inlet_ok_i && (d_in > DW'(dt_slot_i))) ||
                   (nbr_ok && (d_nb > DW'(dt_nbr_i))));
    end
  end
endmodule

// File: rtl/thm_alarm_engine.sv
module thm_alarm_engine
  import thm_pkg::*;
#(
  parameter int W     = 12,
  parameter int NSLOT = 4,
  parameter int CW    = 8,
  localparam int NCH  = NSLOT + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                samp_vld_i,
  input  logic [NCH*W-1:0]    samp_i,
  input  logic [2:0]          cfg_shift_i,
  input  logic signed [W-1:0] cfg_t_high_i,
  input  logic signed [W-1:0] cfg_r_high_i,
  input  logic signed [W-1:0] cfg_dt_slot_i,
  input  logic signed [W-1:0] cfg_dt_sys_i,
  input  logic signed [W-1:0] cfg_dt_nbr_i,
  input  logic signed [W-1:0] cfg_min_i,
  input  logic signed [W-1:0] cfg_max_i,
  input  logic [W-1:0]        cfg_jump_lim_i,
  input  logic [CW-1:0]       cfg_stuck_lim_i,
  input  logic [CW-1:0]       cfg_persist_i,
  output logic [NCH*W-1:0]    smooth_o,
  output logic [NCH-1:0]      healthy_o,
  output logic [NCH-1:0]      abs_alarm_o,
  output logic [NCH-1:0]      rate_alarm_o,
  output logic [NSLOT-1:0]    slot_alert_o,
  output logic                sys_alarm_o,
  output logic                global_alert_o
);
  localparam int DW = W + 1;

  logic signed [W-1:0] sm   [NCH];
  logic signed [W-1:0] smp  [NCH];
  logic [NCH-1:0]      hl;
  logic [NCH-1:0]      abs_c, rate_c;
  logic [NSLOT*W-1:0]  slot_sm;
  logic [NSLOT-1:0]    rel_c;
  logic                v1_q, v1_nx;
  logic                sys_c;
  logic signed [DW-1:0] sys_d;

  // stage 1 -> stage 2 evaluation strobe
  assign v1_nx = samp_vld_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v1_q <= 1'b0;
    else        v1_q <= v1_nx;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [DW-1:0] rise;

    thm_chan #(.W(W), .CW(CW), .KW(3)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .vld_i      (samp_vld_i),
      .raw_i      ($signed(samp_i[c*W +: W])),
      .shift_i    (cfg_shift_i),
      .min_i      (cfg_min_i),
      .max_i      (cfg_max_i),
      .jump_lim_i (cfg_jump_lim_i),
      .stuck_lim_i(cfg_stuck_lim_i),
      .sm_o       (sm[c]),
      .sm_prev_o  (smp[c]),
      .healthy_o  (hl[c])
    );

    assign rise      = DW'(sm[c]) - DW'(smp[c]);
    assign abs_c[c]  = sm[c] > cfg_t_high_i;
    assign rate_c[c] = rise > DW'(cfg_r_high_i);
    assign smooth_o[c*W +: W] = sm[c];

    thm_persist #(.CW(CW)) u_abs (
      .clk(clk), .rst_n(rst_n), .en_i(v1_q), .cond_i(abs_c[c]),
      .limit_i(cfg_persist_i), .alarm_o(abs_alarm_o[c])
    );
    thm_persist #(.CW(CW)) u_rate (
      .clk(clk), .rst_n(rst_n), .en_i(v1_q), .cond_i(rate_c[c]),
      .limit_i(cfg_persist_i), .alarm_o(rate_alarm_o[c])
    );
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_pack
    assign slot_sm[i*W +: W] = sm[SLOT_BASE + i];
  end

  thm_slot_rel #(.W(W), .NSLOT(NSLOT)) u_rel (
    .slot_sm_i (slot_sm),
    .slot_ok_i (hl[NCH-1:SLOT_BASE]),
    .inlet_sm_i(sm[IDX_INLET]),
    .inlet_ok_i(hl[IDX_INLET]),
    .dt_slot_i (cfg_dt_slot_i),
    .dt_nbr_i  (cfg_dt_nbr_i),
    .cond_o    (rel_c)
  );

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot_p
    thm_persist #(.CW(CW)) u_slot (
      .clk(clk), .rst_n(rst_n), .en_i(v1_q), .cond_i(rel_c[i]),
      .limit_i(cfg_persist_i), .alarm_o(slot_alert_o[i])
    );
  end

  assign sys_d = DW'(sm[IDX_OUTLET]) - DW'(sm[IDX_INLET]);
  assign sys_c = hl[IDX_INLET] && hl[IDX_OUTLET] && (sys_d > DW'(cfg_dt_sys_i));

  thm_persist #(.CW(CW)) u_sys (
    .clk(clk), .rst_n(rst_n), .en_i(v1_q), .cond_i(sys_c),
    .limit_i(cfg_persist_i), .alarm_o(sys_alarm_o)
  );

  assign healthy_o      = hl;
  assign global_alert_o = sys_alarm_o || abs_alarm_o[IDX_INLET];

  // R11: slot alerts move only on the cycle after a strobe
  a_r11_slot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !v1_q |=> $stable(slot_alert_o));
  // R7: a system alarm needs both ends healthy when it is raised
  a_r7_sys_health: assert property (@(posedge clk) disable iff (!rst_n)
    (v1_q && !(hl[IDX_INLET] && hl[IDX_OUTLET])) |=> !sys_alarm_o);
endmodule

// File: tb/thm_alarm_engine_tb.sv
module thm_alarm_engine_tb;
  localparam int W = 12;
  localparam int NS = 4;
  localparam int NCH = NS + 2;
  localparam int CW = 8;

  typedef struct packed {
    logic signed [W-1:0] tin, tout, s0, s1, s2, s3;
    logic                sys, glob;
    logic [3:0]          slot;
    logic [5:0]          absm, hm;
  } vec_t;

  // table run: k=0, persist=1, t_high=400, dt_slot=100, dt_sys=150, dt_nbr=60, range -400..1000
  localparam vec_t VEC [8] = '{
    '{12'sd200, 12'sd250, 12'sd220, 12'sd220, 12'sd220, 12'sd220, 1'b0, 1'b0, 4'b0000, 6'h00, 6'h3F},
    '{12'sd200, 12'sd400, 12'sd220, 12'sd220, 12'sd220, 12'sd220, 1'b1, 1'b1, 4'b0000, 6'h00, 6'h3F},
    '{12'sd200, 12'sd250, 12'sd220, 12'sd350, 12'sd220, 12'sd220, 1'b0, 1'b0, 4'b0010, 6'h00, 6'h3F},
    '{12'sd200, 12'sd250, 12'sd220, 12'sd290, 12'sd220, 12'sd220, 1'b0, 1'b0, 4'b0010, 6'h00, 6'h3F},
    '{12'sd200, 12'sd250, 12'sd220, 12'sd220, 12'sd220, 12'sd290, 1'b0, 1'b0, 4'b1000, 6'h00, 6'h3F},
    '{12'sd450, 12'sd500, 12'sd460, 12'sd460, 12'sd460, 12'sd460, 1'b0, 1'b1, 4'b0000, 6'h3F, 6'h3F},
    '{-12'sd500, 12'sd600, 12'sd220, 12'sd220, 12'sd220, 12'sd220, 1'b0, 1'b0, 4'b0000, 6'h02, 6'h3E},
    '{12'sd200, 12'sd250, 12'sd220, 12'sd290, 12'sd1200, 12'sd220, 1'b0, 1'b0, 4'b0010, 6'h10, 6'h2F}
  };

  logic clk, rst_n, vld;
  logic [NCH*W-1:0] samp;
  logic [2:0] c_shift;
  logic signed [W-1:0] c_thi, c_rhi, c_dslot, c_dsys, c_dnbr, c_min, c_max;
  logic [W-1:0] c_jump;
  logic [CW-1:0] c_stuck, c_pers;
  logic [NCH*W-1:0] smooth;
  logic [NCH-1:0] healthy, absa, ratea;
  logic [NS-1:0] slot_al;
  logic sys_al, glob_al;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  thm_alarm_engine #(.W(W), .NSLOT(NS), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .samp_vld_i(vld), .samp_i(samp),
    .cfg_shift_i(c_shift), .cfg_t_high_i(c_thi), .cfg_r_high_i(c_rhi),
    .cfg_dt_slot_i(c_dslot), .cfg_dt_sys_i(c_dsys), .cfg_dt_nbr_i(c_dnbr),
    .cfg_min_i(c_min), .cfg_max_i(c_max), .cfg_jump_lim_i(c_jump),
    .cfg_stuck_lim_i(c_stuck), .cfg_persist_i(c_pers),
    .smooth_o(smooth), .healthy_o(healthy), .abs_alarm_o(absa),
    .rate_alarm_o(ratea), .slot_alert_o(slot_al), .sys_alarm_o(sys_al),
    .global_alert_o(glob_al)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic base_cfg();
    c_shift = 3'd0; c_thi = 12'sd400; c_rhi = 12'sd2047;
    c_dslot = 12'sd100; c_dsys = 12'sd150; c_dnbr = 12'sd60;
    c_min = -12'sd400; c_max = 12'sd1000; c_jump = 12'hFFF;
    c_stuck = 8'd0; c_pers = 8'd1;
  endtask

  task automatic do_reset();
    vld = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic drive(input int a, input int b, input int c, input int d, input int e, input int f);
    samp[0*W +: W] = W'(a); samp[1*W +: W] = W'(b);
    samp[2*W +: W] = W'(c); samp[3*W +: W] = W'(d);
    samp[4*W +: W] = W'(e); samp[5*W +: W] = W'(f);
    vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
  endtask

  // strobe, then let both register stages settle
  task automatic apply(input int a, input int b, input int c, input int d, input int e, input int f);
    drive(a, b, c, d, e, f);
    @(negedge clk);
  endtask

  function automatic int sm_ch(input int ch);
    return int'($signed(smooth[ch*W +: W]));
  endfunction

  initial begin
    #3_000_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    samp = '0;
    base_cfg();
    do_reset();

    // R1 reset state
    chk("R1 healthy", int'(healthy), 0);
    chk("R1 abs", int'(absa), 0);
    chk("R1 rate", int'(ratea), 0);
    chk("R1 slot", int'(slot_al), 0);
    chk("R1 glob", int'({sys_al, glob_al}), 0);

    // table: R3 R4 R7 R8 R9 R10
    for (int v = 0; v < 8; v++) begin
      apply(VEC[v].tin, VEC[v].tout, VEC[v].s0, VEC[v].s1, VEC[v].s2, VEC[v].s3);
      chk($sformatf("R7 sys v%0d", v), int'(sys_al), int'(VEC[v].sys));
      chk($sformatf("R10 glob v%0d", v), int'(glob_al), int'(VEC[v].glob));
      chk($sformatf("R8/R9 slot v%0d", v), int'(slot_al), int'(VEC[v].slot));
      chk($sformatf("R4 abs v%0d", v), int'(absa), int'(VEC[v].absm));
      chk($sformatf("R3 healthy v%0d", v), int'(healthy), int'(VEC[v].hm));
    end

    // R6 persistence and R11 timing
    base_cfg(); c_pers = 8'd3; do_reset();
    apply(200, 400, 220, 220, 220, 220); chk("R6 p1", int'(sys_al), 0);
    apply(200, 400, 220, 220, 220, 220); chk("R6 p2", int'(sys_al), 0);
    drive(200, 400, 220, 220, 220, 220);
    chk("R11 early", int'(sys_al), 0);
    @(negedge clk);
    chk("R11 due", int'(sys_al), 1);
    chk("R10 glob sys", int'(glob_al), 1);
    apply(200, 250, 220, 220, 220, 220); chk("R6 miss", int'(sys_al), 0);
    apply(200, 400, 220, 220, 220, 220); chk("R6 restart", int'(sys_al), 0);

    // R2 smoothing
    base_cfg(); c_shift = 3'd2; do_reset();
    apply(100, 100, 100, 100, 100, 100); chk("R2 seed", sm_ch(0), 100);
    apply(200, 200, 200, 200, 200, 200); chk("R2 k2 a", sm_ch(0), 125);
    apply(200, 200, 200, 200, 200, 200); chk("R2 k2 b", sm_ch(0), 143);
    c_shift = 3'd7;
    apply(303, 303, 303, 303, 303, 303); chk("R2 clamp", sm_ch(5), 153);
    apply(0, 0, 0, 0, 0, 0); chk("R2 fall", sm_ch(1), 143);

    // R5 rate alarm
    base_cfg(); c_pers = 8'd2; c_rhi = 12'sd30; do_reset();
    apply(100, 250, 220, 220, 220, 220); chk("R5 seed", int'(ratea), 0);
    apply(150, 250, 220, 220, 220, 220); chk("R5 once", int'(ratea), 0);
    apply(200, 250, 220, 220, 220, 220); chk("R5 twice", int'(ratea), 1);
    apply(210, 250, 220, 220, 220, 220); chk("R5 slow", int'(ratea), 0);

    // R3 jump exclusion with R7
    base_cfg(); c_jump = 12'd100; do_reset();
    apply(200, 250, 220, 220, 220, 220); chk("R3 base", int'(healthy), 'h3F);
    apply(200, 400, 220, 220, 220, 220);
    chk("R3 jump", int'(healthy), 'h3D);
    chk("R7 excluded", int'(sys_al), 0);
    apply(200, 420, 220, 220, 220, 220);
    chk("R3 recover", int'(healthy), 'h3F);
    chk("R7 back", int'(sys_al), 1);

    // R3 stuck sensor
    base_cfg(); c_stuck = 8'd3; do_reset();
    apply(200, 250, 220, 220, 220, 220);
    apply(200, 250, 220, 220, 220, 220);
    apply(200, 250, 220, 220, 220, 220); chk("R3 not stuck", int'(healthy), 'h3F);
    apply(200, 250, 220, 220, 220, 220); chk("R3 stuck", int'(healthy), 0);
    apply(201, 251, 221, 221, 221, 221); chk("R3 unstuck", int'(healthy), 'h3F);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule